// File: doc/BRIEF.md
# AC-Bias Toggle Generator with Transition Interrupt

This block drives the AC-bias pin of a passive display panel. It counts line-clock strobes and flips the pin level after a programmed number of them, so the drive polarity of the panel supply reverses at regular intervals and no DC charge builds up in the glass. The period is an 8-bit value. The pin keeps toggling for as long as line strobes arrive.

A second counter counts pin transitions. When it reaches a programmed 4-bit target, the block sets a sticky status flag. An interrupt request follows that flag, gated by an enable input. While the flag is set, the transition counter is frozen. Clearing the flag restarts the count from zero. A target of zero turns the count and status function off.

The transition counter is a three-state machine. In `ST_OFF` the target is zero, nothing is counted and the status is low. In `ST_COUNT` toggles are counted. In `ST_HOLD` the status is set and the count is frozen. The transitions are:
- *enable*: `ST_OFF` to `ST_COUNT` when the target becomes non-zero.
- *terminal*: `ST_COUNT` to `ST_HOLD` on the toggle that reaches the target.
- *restart*: `ST_HOLD` to `ST_COUNT` on a clear.
- *disable*: any state to `ST_OFF` when the target is zero.

Top module: `acb_bias_ctrl`

## Requirements
- R1: The pin flips at the clock edge that samples the Nth `line_stb` pulse since the last flip or reset, where N is `tog_period`. No other strobe and no idle cycle changes the pin. Toggling continues while the status is set.
- R2: A `tog_period` of 0 behaves as 1, so the pin flips on every line strobe.
- R3: After reset the pin is 0, the status is 0 and both counters are zero.
- R4: Every pin flip counts as one transition. The flip that brings the count to `trans_per_irq` sets `status` at the same edge as that pin flip.
- R5: While `status` is set, further pin flips are not counted.
- R6: A `stat_clr` pulse drops `status` at the next edge and restarts the transition count from zero. After the clear, exactly `trans_per_irq` further flips are needed to set `status` again.
- R7: If `stat_clr` arrives in the same cycle as the terminal flip, the clear wins. `status` stays 0, and `trans_per_irq` further flips are needed after that cycle.
- R8: A `trans_per_irq` of 0 disables the function. `status` is forced to 0 one edge later and stays 0 whatever the number of flips.
- R9: `irq` equals `status` AND `irq_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_stb | input | 1 | One-cycle line-clock strobe |
| tog_period | input | 8 | Line strobes per pin flip (0 acts as 1) |
| trans_per_irq | input | 4 | Pin flips per status event (0 disables) |
| stat_clr | input | 1 | Status clear pulse |
| irq_en | input | 1 | Interrupt enable |
| bias_out | output | 1 | AC-bias pin level |
| status | output | 1 | Sticky terminal-count status |
| irq | output | 1 | Interrupt request |

## Verification
A software clear and the terminal pin flip can fall in the same cycle. The bench provokes this by driving `stat_clr` high during the very line strobe that completes the target count. It then checks that `status` stays low and that a full new set of flips is needed before it rises. Clears that arrive while the status is held are also checked: flips made during the hold must not have advanced the count.

// File: rtl/acb_pkg.sv
package acb_pkg;
    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_COUNT = 2'd1,
        ST_HOLD  = 2'd2
    } acb_state_e;
endpackage

// File: rtl/acb_line_divider.sv
module acb_line_divider #(
    parameter int PERIOD_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                line_stb,
    input  logic [PERIOD_W-1:0] period,
    output logic                bias,
    output logic                tog_pulse
);
    localparam int EXT_W = PERIOD_W + 1;

    logic [PERIOD_W-1:0] cnt_q;
    logic [PERIOD_W-1:0] eff_period;
    logic                term;
    logic                bias_q;

    always_comb begin
        eff_period = (period == '0) ? PERIOD_W'(1) : period;
        term       = ({1'b0, cnt_q} + EXT_W'(1)) >= {1'b0, eff_period};
        tog_pulse  = line_stb && term;
        bias       = bias_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            bias_q <= 1'b0;
        end else if (line_stb) begin
            cnt_q <= term ? '0 : cnt_q + PERIOD_W'(1);
            if (term) begin
                bias_q <= ~bias_q;
            end
        end
    end

    // R1: the pin never moves without a line strobe
    p_pin_only_on_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !line_stb |=> $stable(bias_q));

    // R2: with period 0 every strobe flips the pin
    p_zero_period_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (line_stb && period == '0) |=> (bias_q != $past(bias_q)));
endmodule

// File: rtl/acb_trans_counter.sv
module acb_trans_counter
    import acb_pkg::*;
#(
    parameter int TRANS_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tog_pulse,
    input  logic [TRANS_W-1:0] limit,
    input  logic               clr,
    output logic               status
);
    localparam int EXT_W = TRANS_W + 1;

    acb_state_e         state_q, state_d;
    logic [TRANS_W-1:0] cnt_q, cnt_d;
    logic               reach;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        reach   = ({1'b0, cnt_q} + EXT_W'(1)) >= {1'b0, limit};
        if (limit == '0) begin
            state_d = ST_OFF;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                ST_OFF: begin
                    state_d = ST_COUNT;
                    cnt_d   = '0;
                end
                ST_COUNT: begin
                    if (clr) begin
                        cnt_d = '0;
                    end else if (tog_pulse) begin
                        if (reach) begin
                            state_d = ST_HOLD;
                            cnt_d   = limit;
                        end else begin
                            cnt_d = cnt_q + TRANS_W'(1);
                        end
                    end
                end
                ST_HOLD: begin
                    if (clr) begin
                        state_d = ST_COUNT;
                        cnt_d   = '0;
                    end
                end
                default: begin
                    state_d = ST_OFF;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        status = (state_q == ST_HOLD);
    end

    // R5: count frozen while status held
    p_hold_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && !clr && limit != '0) |=> $stable(cnt_q));

    // R6 / R7: a clear restarts the count and keeps status low
    p_clr_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0 && state_q != ST_HOLD));

    // R8: disabled target forces status low
    p_off_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (limit == '0) |=> (!status && cnt_q == '0));

    // R4: status only rises on a counted toggle
    p_status_needs_toggle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status) |-> $past(tog_pulse));
endmodule

// File: rtl/acb_bias_ctrl.sv
module acb_bias_ctrl #(
    parameter int PERIOD_W = 8,
    parameter int TRANS_W  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                line_stb,
    input  logic [PERIOD_W-1:0] tog_period,
    input  logic [TRANS_W-1:0]  trans_per_irq,
    input  logic                stat_clr,
    input  logic                irq_en,
    output logic                bias_out,
    output logic                status,
    output logic                irq
);
    logic tog_pulse;

    acb_line_divider #(.PERIOD_W(PERIOD_W)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_stb  (line_stb),
        .period    (tog_period),
        .bias      (bias_out),
        .tog_pulse (tog_pulse)
    );

    acb_trans_counter #(.TRANS_W(TRANS_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tog_pulse (tog_pulse),
        .limit     (trans_per_irq),
        .clr       (stat_clr),
        .status    (status)
    );

    always_comb begin
        irq = status && irq_en;
    end

    // R4: status rises together with a pin flip
    p_status_with_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status) |-> (bias_out != $past(bias_out)));
endmodule

// File: tb/acb_bias_ctrl_tb.sv
module acb_bias_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 8;
    // period, target, strobes, expected pin, expected status
    localparam int VEC [NVEC][5] = '{
        '{3,   2,  5,   1, 0},
        '{3,   2,  6,   0, 1},
        '{0,   1,  1,   1, 1},
        '{1,   0,  7,   1, 0},
        '{4,   3,  11,  0, 0},
        '{2,   15, 30,  1, 1},
        '{5,   4,  19,  1, 0},
        '{255, 1,  255, 1, 1}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_stb = 1'b0;
    logic [7:0] tog_period = 8'd1;
    logic [3:0] trans_per_irq = 4'd0;
    logic       stat_clr = 1'b0;
    logic       irq_en = 1'b0;
    logic       bias_out, status, irq;
    int         checks = 0;
    int         failures = 0;

    acb_bias_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .line_stb(line_stb), .tog_period(tog_period),
        .trans_per_irq(trans_per_irq), .stat_clr(stat_clr), .irq_en(irq_en),
        .bias_out(bias_out), .status(status), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0;
        line_stb = 1'b0; stat_clr = 1'b0;
        @(negedge clk) rst_n = 1'b1;
    endtask

    task automatic strobe(input int n, input logic with_clr);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) line_stb = 1'b1; stat_clr = with_clr;
            @(negedge clk) line_stb = 1'b0; stat_clr = 1'b0;
        end
    endtask

    task automatic clear();
        @(negedge clk) stat_clr = 1'b1;
        @(negedge clk) stat_clr = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 2);
        @(negedge clk) rst_n = 1'b1;
        // R3 reset state
        check("R3 pin", bias_out, 1'b0);
        check("R3 status", status, 1'b0);

        // vector table: R1 R2 R4 R8
        for (int v = 0; v < NVEC; v++) begin
            do_reset();
            tog_period = 8'(VEC[v][0]);
            trans_per_irq = 4'(VEC[v][1]);
            @(negedge clk);
            strobe(VEC[v][2], 1'b0);
            check($sformatf("R1 pin vec%0d", v), bias_out, 1'(VEC[v][3]));
            check($sformatf("R4 status vec%0d", v), status, 1'(VEC[v][4]));
        end

        // R1: idle cycles do not move the pin
        do_reset(); tog_period = 8'd2; trans_per_irq = 4'd0;
        strobe(1, 1'b0);
        repeat (5) @(negedge clk);
        check("R1 idle hold", bias_out, 1'b0);
        strobe(1, 1'b0);
        check("R1 second strobe flips", bias_out, 1'b1);

        // R5 / R6 hold freeze and restart
        do_reset(); tog_period = 8'd1; trans_per_irq = 4'd2; irq_en = 1'b0;
        @(negedge clk);
        strobe(2, 1'b0);
        check("R4 status set", status, 1'b1);
        check("R9 irq masked", irq, 1'b0);
        irq_en = 1'b1; #1;
        check("R9 irq enabled", irq, 1'b1);
        strobe(3, 1'b0);
        check("R5 status held", status, 1'b1);
        check("R1 pin runs during hold", bias_out, 1'b1);
        clear();
        check("R6 status cleared", status, 1'b0);
        check("R9 irq follows", irq, 1'b0);
        strobe(1, 1'b0);
        check("R5 R6 one flip after clear", status, 1'b0);
        strobe(1, 1'b0);
        check("R6 set again after two", status, 1'b1);

        // R7 clear with terminal flip
        do_reset(); tog_period = 8'd1; trans_per_irq = 4'd2;
        @(negedge clk);
        strobe(1, 1'b0);
        strobe(1, 1'b1);
        check("R7 clear wins", status, 1'b0);
        strobe(1, 1'b0);
        check("R7 count restarted", status, 1'b0);
        strobe(1, 1'b0);
        check("R7 set after full count", status, 1'b1);

        // R8 disabling clears status
        trans_per_irq = 4'd0;
        @(negedge clk);
        check("R8 forced low", status, 1'b0);
        strobe(20, 1'b0);
        check("R8 stays low", status, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule